// File: doc/BRIEF.md
# Configurable USART Frame Engine

This block pairs a serial transmitter with a serial receiver, both working to a frame format chosen at run time. A configuration write selects the character width (five to nine data bits), the parity scheme (none, even or odd) and whether the transmitter appends one or two stop bits. The block either runs asynchronously, with a 16x oversampling enable supplied from outside, or synchronously to an external bit clock whose active edges can be swapped by a polarity setting.

Words to send enter through a parallel port with a valid/ready handshake. Each received word is held in a one-word output register together with its parity-error and frame-error flags until it is read. A frame on the line is a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. The line idles high.

Top module: `usart_fe`

## Requirements
- R1: After reset txd is 1, tx_ready is 1 and rx_valid is 0. The format is 8 data bits, no parity, one stop bit, asynchronous mode.
- R2: A transmitted frame is one 0 start bit, then the data bits with bit 0 first, then the parity bit if parity is enabled, then stop bits of value 1. Whenever tx_ready is 1, txd is 1.
- R3: cfg_size codes map 000→5, 001→6, 010→7, 011→8 and 111→9 data bits. Received data bits above the chosen width read as 0.
- R4: cfg_par 00 disables parity. With 10 (even) the parity bit makes the count of ones over data and parity even. With 11 (odd) it makes that count odd.
- R5: cfg_stop2=0 gives one transmit stop bit and 1 gives two. In asynchronous mode a frame lasts 1+N+P+S bit periods from the falling edge of txd to the rise of tx_ready. The receiver checks only the first stop bit and does not depend on cfg_stop2.
- R6: A cfg_size code from 100 to 110, or a cfg_par code of 01, leaves that field at its previous value. The other fields of the same write still take effect.
- R7: If the received parity bit does not match the configured parity over the received data, rx_perr is 1 for that word.
- R8: If the first stop bit is sampled as 0, rx_ferr is 1 for that word.
- R9: In asynchronous mode one bit lasts 16 tick16 pulses. The receiver confirms a start bit half a bit after the falling edge, so a low pulse shorter than that produces no word.
- R10: With cfg_sync=1, bits move only on xck edges. With cfg_pol=0, txd changes after a rising xck edge and rxd is sampled on a falling edge. With cfg_pol=1 these edges are swapped. When xck stops, an accepted frame does not advance.
- R11: rx_valid, rx_data, rx_perr and rx_ferr hold until a cycle with rx_valid and rx_ready both 1, and rx_valid is 0 in the next cycle. A word that completes while the register is still full is dropped.
- R12: A word is accepted on a cycle with tx_valid and tx_ready both 1. tx_ready is then 0 until its frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable at 16 times the bit rate (asynchronous mode) |
| cfg_we | input | 1 | Write strobe for the format fields |
| cfg_size | input | 3 | Character width code |
| cfg_par | input | 2 | Parity mode code |
| cfg_stop2 | input | 1 | Two transmit stop bits when 1 |
| cfg_sync | input | 1 | Synchronous mode when 1 |
| cfg_pol | input | 1 | Swaps xck drive and sample edges |
| tx_data | input | DW | Word to transmit |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter can take a word |
| rx_data | output | DW | Last received word |
| rx_valid | output | 1 | rx_data holds an unread word |
| rx_ready | input | 1 | Consumer reads the word |
| rx_perr | output | 1 | Parity error of the held word |
| rx_ferr | output | 1 | Frame error of the held word |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| xck | input | 1 | External bit clock (synchronous mode) |

## Verification
The bench uses the default DW=9 and OSR=16 and pulses tick16 every second clock. One bit period is then exactly 32 clocks, so the frame length up to tx_ready can be checked to the cycle for every combination of width, parity and stop count, including 9-bit characters. The external xck toggles every 8 clocks, which leaves room for the input synchronizer. With that margin, a bench monitor can attribute each txd change to the xck level of the selected polarity. Frames with faulty parity, a low stop bit or a short start glitch are driven into rxd directly, with txd loopback switched off.

// File: rtl/usart_fe_pkg.sv
package usart_fe_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_RSVD = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_ODD  = 2'b11
  } par_e;

  typedef struct packed {
    logic [2:0] size;
    par_e       par;
    logic       stop2;
    logic       sync;
    logic       pol;
  } cfg_t;

  localparam cfg_t CFG_RST = '{size: 3'b011, par: PAR_NONE, stop2: 1'b0, sync: 1'b0, pol: 1'b0};

  function automatic logic size_ok(input logic [2:0] code);
    return (code <= 3'b011) || (code == 3'b111);
  endfunction

  function automatic logic [3:0] size_bits(input logic [2:0] code);
    case (code)
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/usart_fe_cfg.sv
module usart_fe_cfg
  import usart_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [2:0] size,
  input  logic [1:0] par,
  input  logic       stop2,
  input  logic       sync,
  input  logic       pol,
  output cfg_t       cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RST;
    end else if (we) begin
      if (size_ok(size)) cfg_q.size <= size;
      if (par != PAR_RSVD) cfg_q.par <= par_e'(par);
      cfg_q.stop2 <= stop2;
      cfg_q.sync  <= sync;
      cfg_q.pol   <= pol;
    end
  end
endmodule

// File: rtl/usart_fe_tx.sv
module usart_fe_tx
  import usart_fe_pkg::*;
#(
  parameter int DW  = 9,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          drv_edge,
  input  cfg_t          cfg,
  input  logic [DW-1:0] data,
  input  logic          valid,
  output logic          ready,
  output logic          txd
);
  localparam int FW = DW + 4;
  localparam int CW = $clog2(OSR);
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0] frame, sh;
  logic [LW-1:0] flen, rem;
  logic [CW-1:0] phase;
  logic [DW-1:0] dm;
  logic [3:0]    nd;
  logic          pen, pbit, busy, step;

  always_comb begin
    nd  = size_bits(cfg.size);
    pen = (cfg.par != PAR_NONE);
    dm  = '0;
    for (int i = 0; i < DW; i++)
      if (i < int'(nd)) dm[i] = data[i];
    pbit  = (^dm) ^ (cfg.par == PAR_ODD);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i < int'(nd)) frame[i+1] = data[i];
    if (pen) frame[nd+1] = pbit;
    flen = LW'(nd) + LW'(pen) + LW'(cfg.stop2) + LW'(2);
  end

  assign step  = cfg.sync ? drv_edge : (tick && phase == CW'(OSR - 1));
  assign ready = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      sh    <= '1;
      rem   <= '0;
      phase <= '0;
    end else if (!busy) begin
      if (valid) begin
        busy  <= 1'b1;
        sh    <= frame;
        rem   <= flen;
        phase <= CW'(OSR - 1);
      end
    end else begin
      if (tick) phase <= phase + 1'b1;
      if (step) begin
        if (rem != '0) begin
          txd <= sh[0];
          sh  <= {1'b1, sh[FW-1:1]};
          rem <= rem - 1'b1;
        end else begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/usart_fe_rx.sv
module usart_fe_rx
  import usart_fe_pkg::*;
#(
  parameter int DW  = 9,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          smp_edge,
  input  cfg_t          cfg,
  input  logic          rxd,
  input  logic          rd,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_perr,
  output logic          rx_ferr
);
  localparam int BW = DW + 2;
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(BW + 1);

  typedef enum logic [1:0] {S_IDLE, S_HUNT, S_DATA} st_e;
  st_e           st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [BW-1:0] buf_q, nb;
  logic [DW-1:0] d;
  logic [3:0]    nd;
  logic          pen, take, last, perr_n, stop_b;

  always_comb begin
    nd  = size_bits(cfg.size);
    pen = (cfg.par != PAR_NONE);
    nb  = buf_q;
    nb[idx] = rxd;
    d = '0;
    for (int i = 0; i < DW; i++)
      if (i < int'(nd)) d[i] = nb[i];
    perr_n = pen && (nb[nd] != ((^d) ^ (cfg.par == PAR_ODD)));
    stop_b = nb[nd + {3'b000, pen}];
    last   = (idx == IW'(nd) + IW'(pen));
    take   = (st == S_DATA) && (cfg.sync ? smp_edge : (tick && cnt == CW'(OSR - 1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      buf_q    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      if (rx_valid && rd) rx_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          idx <= '0;
          if (cfg.sync) begin
            if (smp_edge && !rxd) st <= S_DATA;
          end else if (tick && !rxd) begin
            st <= S_HUNT;
          end
        end
        S_HUNT: if (tick) begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(OSR / 2 - 1)) begin
            cnt <= '0;
            st  <= rxd ? S_IDLE : S_DATA;
          end
        end
        default: begin
          if (tick && !cfg.sync) cnt <= cnt + 1'b1;
          if (take) begin
            buf_q <= nb;
            idx   <= idx + 1'b1;
            if (last) begin
              st <= S_IDLE;
              if (!rx_valid || rd) begin
                rx_data  <= d;
                rx_perr  <= perr_n;
                rx_ferr  <= !stop_b;
                rx_valid <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/usart_fe.sv
module usart_fe
  import usart_fe_pkg::*;
#(
  parameter int DW  = 9,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_size,
  input  logic [1:0]    cfg_par,
  input  logic          cfg_stop2,
  input  logic          cfg_sync,
  input  logic          cfg_pol,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic          rx_perr,
  output logic          rx_ferr,
  output logic          txd,
  input  logic          rxd,
  input  logic          xck
);
  cfg_t       cfg_q;
  logic [2:0] xck_sr;
  logic [1:0] rxd_sr;
  logic       x_rise, x_fall, drv_edge, smp_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      xck_sr <= '0;
      rxd_sr <= '1;
    end else begin
      xck_sr <= {xck_sr[1:0], xck};
      rxd_sr <= {rxd_sr[0], rxd};
    end
  end

  assign x_rise   = xck_sr[1] & ~xck_sr[2];
  assign x_fall   = ~xck_sr[1] & xck_sr[2];
  assign drv_edge = cfg_q.pol ? x_fall : x_rise;
  assign smp_edge = cfg_q.pol ? x_rise : x_fall;

  usart_fe_cfg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .size(cfg_size), .par(cfg_par),
    .stop2(cfg_stop2), .sync(cfg_sync), .pol(cfg_pol), .cfg_q(cfg_q)
  );

  usart_fe_tx #(.DW(DW), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick16), .drv_edge(drv_edge), .cfg(cfg_q),
    .data(tx_data), .valid(tx_valid), .ready(tx_ready), .txd(txd)
  );

  usart_fe_rx #(.DW(DW), .OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick16), .smp_edge(smp_edge), .cfg(cfg_q),
    .rxd(rxd_sr[1]), .rd(rx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );
endmodule

// File: rtl/usart_fe_chk.sv
module usart_fe_chk
  import usart_fe_pkg::*;
#(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          txd,
  input logic [DW-1:0] rx_data,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          rx_perr,
  input logic          rx_ferr,
  input cfg_t          cfg_q
);
  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> txd);

  // R12
  tx_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R11
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_perr) && $stable(rx_ferr)));

  // R11
  rx_clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_valid) |-> $past(rx_ready));

  // R6
  size_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.size <= 3'b011) || (cfg_q.size == 3'b111));

  // R6
  par_legal_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_q.par != PAR_RSVD);
endmodule

bind usart_fe usart_fe_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_perr(rx_perr), .rx_ferr(rx_ferr), .cfg_q(cfg_q)
);

// File: tb/usart_fe_bench.sv
`timescale 1ns/100ps
module usart_fe_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_size = 3'b011;
  logic [1:0] cfg_par = 2'b00;
  logic       cfg_stop2 = 1'b0, cfg_sync = 1'b0, cfg_pol = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_valid = 1'b0, tx_ready;
  logic [8:0] rx_data;
  logic       rx_valid, rx_ready = 1'b0, rx_perr, rx_ferr;
  logic       txd, rxd, xck = 1'b0;
  logic       loop_en = 1'b1, bb_line = 1'b1, xck_run = 1'b1;
  logic       mon_en = 1'b0, prev_txd = 1'b1;
  int         nchk = 0, nerr = 0, bad_edge = 0;
  logic [2:0] e_size = 3'b011;
  logic [1:0] e_par = 2'b00;
  logic       e_stop2 = 1'b0;

  assign rxd = loop_en ? txd : bb_line;

  usart_fe u_usart_fe (
    .clk(clk), .rst(rst), .tick16(tick16), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .cfg_sync(cfg_sync), .cfg_pol(cfg_pol),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .txd(txd), .rxd(rxd), .xck(xck)
  );

  initial forever #2.5 clk = ~clk;
  initial forever begin @(negedge clk); tick16 <= ~tick16; end
  initial forever begin repeat (8) @(negedge clk); if (xck_run) xck <= ~xck; end

  always @(negedge clk) begin
    if (mon_en && txd !== prev_txd && xck !== ~cfg_pol) bad_edge++;
    prev_txd <= txd;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nd_of(input logic [2:0] c);
    case (c)
      3'b000: return 5;
      3'b001: return 6;
      3'b010: return 7;
      3'b111: return 9;
      default: return 8;
    endcase
  endfunction

  function automatic logic [8:0] mask_d(input logic [8:0] d);
    return d & 9'((1 << nd_of(e_size)) - 1);
  endfunction

  function automatic logic pbit_of(input logic [8:0] d);
    return (^mask_d(d)) ^ (e_par == 2'b11);
  endfunction

  function automatic int flen_of();
    return 2 + nd_of(e_size) + (e_par != 2'b00 ? 1 : 0) + (e_stop2 ? 1 : 0);
  endfunction

  function automatic logic [15:0] fbits_of(input logic [8:0] d);
    logic [15:0] f = '1;
    int n = nd_of(e_size);
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) f[i+1] = d[i];
    if (e_par != 2'b00) f[n+1] = pbit_of(d);
    return f;
  endfunction

  task automatic set_cfg(input logic [2:0] s, input logic [1:0] p, input logic st,
                         input logic sy, input logic po);
    @(negedge clk);
    cfg_size = s; cfg_par = p; cfg_stop2 = st; cfg_sync = sy; cfg_pol = po; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s <= 3'b011 || s == 3'b111) e_size = s;
    if (p != 2'b01) e_par = p;
    e_stop2 = st;
  endtask

  task automatic send(input logic [8:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx();
    int k = 0;
    while (!rx_valid && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic read_rx();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R11 cleared after read", rx_valid, 0);
  endtask

  task automatic check_word(input logic [8:0] d, input logic ep, input logic ef, input string tag);
    wait_rx();
    chk(rx_valid == 1'b1, {tag, " word received"}, rx_valid, 1);
    chk(rx_data == mask_d(d), {tag, " R3 data"}, rx_data, mask_d(d));
    chk(rx_perr == ep, {tag, " R7 parity flag"}, rx_perr, ep);
    chk(rx_ferr == ef, {tag, " R8 frame flag"}, rx_ferr, ef);
  endtask

  task automatic run_async(input logic [8:0] d, input string tag);
    int n = flen_of();
    logic [15:0] fb = fbits_of(d);
    int c = 0;
    int badbit = -1;
    send(d);
    while (txd !== 1'b0) @(negedge clk);
    while (!tx_ready && c < 1000) begin
      @(negedge clk); c++;
      if (c % 32 == 16 && c / 32 < n && txd !== fb[c/32] && badbit < 0) badbit = c / 32;
    end
    chk(badbit < 0, {tag, " R2 R4 frame bit order"}, badbit, -1);
    chk(c == 32 * n, {tag, " R5 frame length"}, c, 32 * n);
    check_word(d, 1'b0, 1'b0, tag);
    read_rx();
  endtask

  task automatic run_sync(input logic [8:0] d, input string tag);
    bad_edge = 0;
    mon_en = 1'b1;
    send(d);
    check_word(d, 1'b0, 1'b0, tag);
    while (!tx_ready) @(negedge clk);
    mon_en = 1'b0;
    chk(bad_edge == 0, {tag, " R10 txd changes on drive edge"}, bad_edge, 0);
    read_rx();
  endtask

  task automatic bb_bit(input logic b);
    bb_line = b;
    repeat (32) @(negedge clk);
  endtask

  task automatic bb_frame(input logic [8:0] d, input logic pb, input logic sb);
    bb_bit(1'b0);
    for (int i = 0; i < nd_of(e_size); i++) bb_bit(d[i]);
    if (e_par != 2'b00) bb_bit(pb);
    bb_bit(sb);
    bb_line = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    // R1 default format: 8 bits, no parity, one stop
    run_async(9'h1A5, "R1 default");

    // R3 R4 R5 directed: 9 bits, odd, two stops; 5 bits, even
    set_cfg(3'b111, 2'b11, 1'b1, 1'b0, 1'b0);
    run_async(9'h155, "R3 nine-bit");
    set_cfg(3'b000, 2'b10, 1'b0, 1'b0, 1'b0);
    run_async(9'h1F3, "R3 five-bit");

    // R6 reserved codes keep 5-bit even, stop2 still applies
    set_cfg(3'b101, 2'b01, 1'b1, 1'b0, 1'b0);
    run_async(9'h00D, "R6 reserved");

    // random asynchronous formats
    for (int t = 0; t < 16; t++) begin
      int rs = $urandom % 5;
      int rp = $urandom % 3;
      set_cfg(rs == 4 ? 3'b111 : 3'(rs), rp == 0 ? 2'b00 : 2'(rp + 1), 1'($urandom), 1'b0, 1'b0);
      run_async(9'($urandom), "R2 R5 random async");
    end

    // R10 synchronous mode, both polarities
    for (int t = 0; t < 10; t++) begin
      int rs = $urandom % 5;
      int rp = $urandom % 3;
      set_cfg(rs == 4 ? 3'b111 : 3'(rs), rp == 0 ? 2'b00 : 2'(rp + 1), 1'($urandom), 1'b1, 1'(t % 2));
      run_sync(9'($urandom), t % 2 ? "R10 pol1" : "R10 pol0");
    end

    // R10 stopped xck: accepted frame does not advance
    xck_run = 1'b0;
    set_cfg(3'b011, 2'b00, 1'b0, 1'b1, 1'b0);
    send(9'h000);
    repeat (200) @(negedge clk);
    chk(txd == 1'b1, "R10 no xck keeps line", txd, 1);
    chk(tx_ready == 1'b0, "R12 busy after accept", tx_ready, 0);
    xck_run = 1'b1;
    check_word(9'h000, 1'b0, 1'b0, "R10 resumed");
    read_rx();

    // R7 parity error, held across idle time (R11)
    set_cfg(3'b011, 2'b10, 1'b0, 1'b0, 1'b0);
    loop_en = 1'b0;
    repeat (64) @(negedge clk);
    bb_frame(9'h0A5, 1'b1, 1'b1);
    check_word(9'h0A5, 1'b1, 1'b0, "R7 bad parity");
    repeat (300) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_perr == 1'b1, "R11 flags held", rx_perr, 1);
    read_rx();

    // R8 low stop bit, odd parity correct
    set_cfg(3'b010, 2'b11, 1'b0, 1'b0, 1'b0);
    bb_frame(9'h013, pbit_of(9'h013), 1'b0);
    check_word(9'h013, 1'b0, 1'b1, "R8 low stop");
    read_rx();
    repeat (64) @(negedge clk);

    // R5 receiver ignores stop2: second stop slot driven low
    set_cfg(3'b011, 2'b00, 1'b1, 1'b0, 1'b0);
    bb_frame(9'h03C, 1'b0, 1'b1);
    bb_bit(1'b0);
    bb_line = 1'b1;
    check_word(9'h03C, 1'b0, 1'b0, "R5 rx single stop");
    read_rx();
    repeat (600) @(negedge clk);
    if (rx_valid) read_rx();

    // R9 short start glitch is rejected
    bb_line = 1'b0;
    repeat (8) @(negedge clk);
    bb_line = 1'b1;
    repeat (600) @(negedge clk);
    chk(rx_valid == 1'b0, "R9 glitch rejected", rx_valid, 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule